// File: doc/BRIEF.md
# Per-Thread Partitioned Store Buffer with Load Forwarding

This block holds retired stores between a core and its L1 data cache. Two hardware threads share it, and each owns a fixed partition of entries, so one thread can never consume another thread's space. Within a partition, stores leave for the cache strictly in the order they arrived. Both partitions compete for one cache write port, and they take it in turns. The cache accepts a store with a valid/ready handshake and may refuse it for as many cycles as it needs.

Every thread has its own load lookup port. A load is compared against the uncommitted stores of its own thread only. The newest store to the same word address decides the result. If that store supplies every byte the load asks for, its data is returned and the cache need not be read. If it supplies only some of them, the load has to wait. A load that matches nothing goes on to the cache.

A thread may raise a full fence. Its loads are then held back until every store that thread had buffered at the fence has reached the cache. Stores issued after the fence do not lengthen the wait. The other thread carries on as before.

Top module: `sbuf_top`

## Requirements
- R1: Each partition presents its stores to the commit port in arrival order. The commit port shows valid whenever any partition holds an entry, and its address, data and byte mask are those of the oldest entry of the thread it names.
- R2: A partition of DEPTH entries raises its thread's full output when it holds DEPTH entries. A store offered to a full partition is dropped and is never committed.
- R3: While commit valid is high and ready is low, the thread, address, data and mask on the commit port stay unchanged in the next cycle.
- R4: When a store from thread t is accepted by the cache and another partition still holds entries, the next store offered comes from a thread other than t.
- R5: A load hits when the newest entry of its own thread with an equal word address has a byte mask covering the load's byte mask (bit i is byte i, bits 7:0 of the data). It then returns that entry's full 32-bit data with hit high and stall low, in the same cycle.
- R6: When the newest matching entry does not cover every byte of the load mask, the load is stalled: stall is high and hit is low, even if older entries would cover the rest.
- R7: A load never hits on stores buffered by the other thread.
- R8: A fence from thread t stalls every load of thread t, beginning in the cycle after the fence, until all entries buffered in t's partition at the end of the fence cycle have committed. A store enqueued in the fence cycle counts as buffered before the fence. Loads of the other thread are not affected.
- R9: After reset no partition holds entries: commit valid is low and every full output is low.
- R10: A load with no matching entry in its own partition, and no fence pending, has both hit and stall low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_vld_i | input | THREADS | Per-thread store request |
| st_addr_i | input | THREADS x 32 | Per-thread store word address |
| st_data_i | input | THREADS x 32 | Per-thread store data |
| st_mask_i | input | THREADS x 4 | Per-thread store byte mask |
| st_full_o | output | THREADS | Partition full; stores are dropped while high |
| fence_i | input | THREADS | Per-thread full fence pulse |
| ld_vld_i | input | THREADS | Per-thread load lookup request |
| ld_addr_i | input | THREADS x 32 | Load word address |
| ld_mask_i | input | THREADS x 4 | Load byte mask |
| ld_hit_o | output | THREADS | Load satisfied from the buffer |
| ld_stall_o | output | THREADS | Load must wait (partial overlap or fence) |
| ld_data_o | output | THREADS x 32 | Forwarded data, zero when no hit |
| cm_valid_o | output | 1 | A store is offered to the cache |
| cm_thread_o | output | TW | Thread that owns the offered store |
| cm_addr_o | output | 32 | Offered store address |
| cm_data_o | output | 32 | Offered store data |
| cm_mask_o | output | 4 | Offered store byte mask |
| cm_ready_i | input | 1 | Cache accepts the offered store |

## Verification
The bench builds the block with two threads and DEPTH of 4. The shallow partition fills after only a few stores, so random traffic often reaches the full and dropped-store case of R2. It also keeps both partitions busy at the same time, which exercises the turn-taking of R4 and the hold-under-refusal of R3. Word addresses come from a set of four, so the bench regularly produces chains of several stores to one address with different masks. Those chains cover newest-entry selection and the partial-overlap stall (R5, R6). Fences are mixed into the same traffic, so the R8 wait often overlaps with stores that arrive after the fence.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    localparam int unsigned SB_AW = 32;
    localparam int unsigned SB_DW = 32;
    localparam int unsigned SB_MW = SB_DW / 8;

    // One buffered store: word address, data and byte enables
    typedef struct packed {
        logic [SB_AW-1:0] addr;
        logic [SB_DW-1:0] data;
        logic [SB_MW-1:0] mask;
    } sb_entry_t;
endpackage

// File: rtl/sbuf_part.sv
// One thread's partition: circular FIFO, youngest-match lookup, fence counter
module sbuf_part
    import sbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  sb_entry_t        push_ent_i,
    input  logic             pop_i,
    input  logic             fence_i,
    input  logic [SB_AW-1:0] look_addr_i,
    output logic             full_o,
    output logic             busy_o,
    output logic             fence_wait_o,
    output sb_entry_t        head_o,
    output logic             look_hit_o,
    output sb_entry_t        look_ent_o
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        sb_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         head;
        logic [PW-1:0]         tail;
        logic [CW-1:0]         cnt;
        logic [CW-1:0]         fcnt;   // entries still owed before fenced loads may go
    } part_st_t;

    part_st_t      st_q, st_d;
    logic          push_ok;
    logic [PW-1:0] slot;

    always_comb begin
        st_d    = st_q;
        push_ok = push_i && (st_q.cnt != CW'(DEPTH));
        if (push_ok) begin
            st_d.mem[st_q.tail] = push_ent_i;
            st_d.tail           = st_q.tail + PW'(1);
        end
        if (pop_i) begin
            st_d.head = st_q.head + PW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_i);
        // A fence owes everything present once this cycle settles
        if (fence_i) begin
            st_d.fcnt = st_d.cnt;
        end else if (pop_i && (st_q.fcnt != '0)) begin
            st_d.fcnt = st_q.fcnt - CW'(1);
        end

        // Walk oldest to newest; the last hit seen is the youngest
        look_hit_o = 1'b0;
        look_ent_o = '0;
        slot       = '0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = st_q.head + PW'(i);
            if ((CW'(i) < st_q.cnt) && (st_q.mem[slot].addr == look_addr_i)) begin
                look_hit_o = 1'b1;
                look_ent_o = st_q.mem[slot];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o       = (st_q.cnt == CW'(DEPTH));
    assign busy_o       = (st_q.cnt != '0);
    assign fence_wait_o = (st_q.fcnt != '0);
    assign head_o       = st_q.mem[st_q.head];
endmodule

// File: rtl/sbuf_rr.sv
// Round-robin grant for the single commit port, locked while refused
module sbuf_rr #(
    parameter int unsigned N = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N-1:0]                 req_i,
    input  logic                         ready_i,
    output logic                         valid_o,
    output logic [((N>1)?$clog2(N):1)-1:0] idx_o
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IW-1:0] ptr;    // first thread to consider
        logic          hold;   // an offer was refused last cycle
        logic [IW-1:0] hidx;
    } rr_st_t;

    rr_st_t        st_q, st_d;
    logic [IW-1:0] cand;

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        cand    = '0;
        if (st_q.hold) begin
            valid_o = 1'b1;
            idx_o   = st_q.hidx;
        end else begin
            // Scan backwards so the candidate nearest the pointer wins
            for (int k = N - 1; k >= 0; k--) begin
                cand = IW'((int'(st_q.ptr) + k) % N);
                if (req_i[cand]) begin
                    valid_o = 1'b1;
                    idx_o   = cand;
                end
            end
        end

        st_d      = st_q;
        st_d.hold = valid_o && !ready_i;
        st_d.hidx = idx_o;
        if (valid_o && ready_i) begin
            st_d.ptr = (idx_o == IW'(N - 1)) ? '0 : idx_o + IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
    import sbuf_pkg::*;
#(
    parameter  int unsigned THREADS = 2,
    parameter  int unsigned DEPTH   = 8,
    localparam int unsigned TW      = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [THREADS-1:0]             st_vld_i,
    input  logic [THREADS-1:0][SB_AW-1:0]  st_addr_i,
    input  logic [THREADS-1:0][SB_DW-1:0]  st_data_i,
    input  logic [THREADS-1:0][SB_MW-1:0]  st_mask_i,
    output logic [THREADS-1:0]             st_full_o,
    input  logic [THREADS-1:0]             fence_i,
    input  logic [THREADS-1:0]             ld_vld_i,
    input  logic [THREADS-1:0][SB_AW-1:0]  ld_addr_i,
    input  logic [THREADS-1:0][SB_MW-1:0]  ld_mask_i,
    output logic [THREADS-1:0]             ld_hit_o,
    output logic [THREADS-1:0]             ld_stall_o,
    output logic [THREADS-1:0][SB_DW-1:0]  ld_data_o,
    output logic                           cm_valid_o,
    output logic [TW-1:0]                  cm_thread_o,
    output logic [SB_AW-1:0]               cm_addr_o,
    output logic [SB_DW-1:0]               cm_data_o,
    output logic [SB_MW-1:0]               cm_mask_o,
    input  logic                           cm_ready_i
);
    sb_entry_t          head_w     [THREADS];
    sb_entry_t          look_ent_w [THREADS];
    sb_entry_t          push_ent_w [THREADS];
    logic [THREADS-1:0] part_busy;
    logic [THREADS-1:0] fence_wait;
    logic [THREADS-1:0] look_hit;
    logic [THREADS-1:0] covered;
    logic [THREADS-1:0] pop_w;
    sb_entry_t          cm_ent;

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        assign push_ent_w[t] = '{addr: st_addr_i[t], data: st_data_i[t], mask: st_mask_i[t]};
        assign pop_w[t]      = cm_valid_o && cm_ready_i && (cm_thread_o == TW'(t));

        sbuf_part #(.DEPTH(DEPTH)) u_part (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (st_vld_i[t]),
            .push_ent_i  (push_ent_w[t]),
            .pop_i       (pop_w[t]),
            .fence_i     (fence_i[t]),
            .look_addr_i (ld_addr_i[t]),
            .full_o      (st_full_o[t]),
            .busy_o      (part_busy[t]),
            .fence_wait_o(fence_wait[t]),
            .head_o      (head_w[t]),
            .look_hit_o  (look_hit[t]),
            .look_ent_o  (look_ent_w[t])
        );

        // Forward only if the youngest match supplies every requested byte
        always_comb begin
            covered[t]    = (ld_mask_i[t] & ~look_ent_w[t].mask) == '0;
            ld_hit_o[t]   = ld_vld_i[t] && !fence_wait[t] && look_hit[t] && covered[t];
            ld_stall_o[t] = ld_vld_i[t] && (fence_wait[t] || (look_hit[t] && !covered[t]));
            ld_data_o[t]  = ld_hit_o[t] ? look_ent_w[t].data : '0;
        end
    end

    sbuf_rr #(.N(THREADS)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (part_busy),
        .ready_i(cm_ready_i),
        .valid_o(cm_valid_o),
        .idx_o  (cm_thread_o)
    );

    assign cm_ent    = head_w[cm_thread_o];
    assign cm_addr_o = cm_ent.addr;
    assign cm_data_o = cm_ent.data;
    assign cm_mask_o = cm_ent.mask;
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk #(
    parameter int unsigned THREADS = 2,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned TW      = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [THREADS-1:0] st_full_o,
    input logic [THREADS-1:0] fence_i,
    input logic [THREADS-1:0] ld_vld_i,
    input logic [THREADS-1:0] ld_hit_o,
    input logic [THREADS-1:0] ld_stall_o,
    input logic               cm_valid_o,
    input logic               cm_ready_i,
    input logic [TW-1:0]      cm_thread_o,
    input logic [31:0]        cm_addr_o,
    input logic [31:0]        cm_data_o,
    input logic [3:0]         cm_mask_o,
    input logic [THREADS-1:0] part_busy
);
    // R3: a refused offer is repeated unchanged
    p_commit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid_o && !cm_ready_i |=> cm_valid_o && $stable(cm_thread_o) &&
        $stable(cm_addr_o) && $stable(cm_data_o) && $stable(cm_mask_o));

    // R1: any buffered entry is offered to the cache
    p_busy_offers_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|part_busy) |-> cm_valid_o);

    for (genvar t = 0; t < THREADS; t++) begin : g_chk
        // R2: a full partition always has something on the commit port
        p_full_offers_r2: assert property (@(posedge clk) disable iff (!rst_n)
            st_full_o[t] |-> cm_valid_o);

        // R8: fencing a full partition stalls the next cycle's load
        p_fence_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
            fence_i[t] && st_full_o[t] |=> !ld_vld_i[t] || (ld_stall_o[t] && !ld_hit_o[t]));

        // R4: after t commits, a waiting partition gets the next turn
        p_rr_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cm_valid_o && cm_ready_i && (cm_thread_o == TW'(t)) &&
            ((part_busy & ~(THREADS'(1) << t)) != '0)
            |=> cm_valid_o && (cm_thread_o != TW'(t)));

        // R6: a load is never both forwarded and stalled
        p_hit_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ld_hit_o[t] |-> ld_vld_i[t] && !ld_stall_o[t]);
    end
endmodule

bind sbuf_top sbuf_chk #(.THREADS(THREADS), .DEPTH(DEPTH), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_full_o  (st_full_o),
    .fence_i    (fence_i),
    .ld_vld_i   (ld_vld_i),
    .ld_hit_o   (ld_hit_o),
    .ld_stall_o (ld_stall_o),
    .cm_valid_o (cm_valid_o),
    .cm_ready_i (cm_ready_i),
    .cm_thread_o(cm_thread_o),
    .cm_addr_o  (cm_addr_o),
    .cm_data_o  (cm_data_o),
    .cm_mask_o  (cm_mask_o),
    .part_busy  (part_busy)
);

// File: tb/test_sbuf_top.sv
module test_sbuf_top;
    import sbuf_pkg::*;

    localparam int TH = 2;
    localparam int DP = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst_n;
    logic [TH-1:0]        st_vld, st_full, fence, ld_vld, ld_hit, ld_stall;
    logic [TH-1:0][31:0]  st_addr, st_data, ld_addr, ld_data;
    logic [TH-1:0][3:0]   st_mask, ld_mask;
    logic                 cm_valid, cm_ready;
    logic [0:0]           cm_thread;
    logic [31:0]          cm_addr, cm_data;
    logic [3:0]           cm_mask;

    sbuf_top #(.THREADS(TH), .DEPTH(DP)) i_sbuf_top (
        .clk(clk), .rst_n(rst_n),
        .st_vld_i(st_vld), .st_addr_i(st_addr), .st_data_i(st_data), .st_mask_i(st_mask),
        .st_full_o(st_full), .fence_i(fence),
        .ld_vld_i(ld_vld), .ld_addr_i(ld_addr), .ld_mask_i(ld_mask),
        .ld_hit_o(ld_hit), .ld_stall_o(ld_stall), .ld_data_o(ld_data),
        .cm_valid_o(cm_valid), .cm_thread_o(cm_thread), .cm_addr_o(cm_addr),
        .cm_data_o(cm_data), .cm_mask_o(cm_mask), .cm_ready_i(cm_ready)
    );

    sb_entry_t mq [TH][$];
    int        fcnt_m [TH];
    int        n_chk = 0;
    int        n_bad = 0;
    bit        done = 1'b0;
    bit        prev_hold = 1'b0;
    logic [68:0] prev_off;
    int        last_hs = -1;

    function automatic sb_entry_t mk(logic [31:0] a, logic [31:0] d, logic [3:0] m);
        sb_entry_t e;
        e.addr = a; e.data = d; e.mask = m;
        return e;
    endfunction

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected load outcome from the bench's own queue of thread t
    task automatic exp_load(int t, logic [31:0] a, logic [3:0] m,
                            output bit hit, output bit stall, output logic [31:0] d,
                            output string tag);
        hit = 0; stall = 0; d = '0; tag = "R10";
        if (fcnt_m[t] > 0) begin
            stall = 1; tag = "R8";
            return;
        end
        for (int i = mq[t].size() - 1; i >= 0; i--) begin
            if (mq[t][i].addr == a) begin
                if ((m & ~mq[t][i].mask) == 4'h0) begin
                    hit = 1; d = mq[t][i].data; tag = "R5";
                end else begin
                    stall = 1; tag = "R6";
                end
                return;
            end
        end
    endtask

    task automatic idle();
        st_vld = '0; fence = '0; ld_vld = '0;
    endtask

    // Inputs are set just after a falling edge; check, advance model, next edge
    task automatic step(string ltag = "");
        bit any, eh, es, hs;
        logic [31:0] ed;
        string tg;
        #2;
        any = 0;
        for (int t = 0; t < TH; t++) any |= (mq[t].size() > 0);
        chk("R1", "commit valid", cm_valid, any);
        if (cm_valid && mq[cm_thread].size() > 0)
            chk("R1", "commit entry", {cm_addr, cm_data, cm_mask}, mq[cm_thread][0]);
        if (prev_hold)
            chk("R3", "held offer", {cm_thread, cm_addr, cm_data, cm_mask}, prev_off);
        if (last_hs >= 0 && mq[1 - last_hs].size() > 0)
            chk("R4", "turn", cm_thread, 1 - last_hs);
        for (int t = 0; t < TH; t++) begin
            chk("R2", "full", st_full[t], mq[t].size() == DP);
            if (ld_vld[t]) begin
                exp_load(t, ld_addr[t], ld_mask[t], eh, es, ed, tg);
                if (ltag != "") tg = ltag;
                chk(tg, "load hit", ld_hit[t], eh);
                chk(tg, "load stall", ld_stall[t], es);
                if (eh) chk(tg, "load data", ld_data[t], ed);
            end
        end
        hs        = cm_valid && cm_ready;
        prev_hold = cm_valid && !cm_ready;
        prev_off  = {cm_thread, cm_addr, cm_data, cm_mask};
        for (int t = 0; t < TH; t++)
            if (st_vld[t] && mq[t].size() < DP)
                mq[t].push_back(mk(st_addr[t], st_data[t], st_mask[t]));
        if (hs && mq[cm_thread].size() > 0) begin
            void'(mq[cm_thread].pop_front());
            if (fcnt_m[cm_thread] > 0) fcnt_m[cm_thread]--;
        end
        for (int t = 0; t < TH; t++)
            if (fence[t]) fcnt_m[t] = mq[t].size();
        last_hs = hs ? int'(cm_thread) : -1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(int t, logic [31:0] a, logic [31:0] d, logic [3:0] m);
        st_vld[t] = 1; st_addr[t] = a; st_data[t] = d; st_mask[t] = m;
    endtask

    task automatic load(int t, logic [31:0] a, logic [3:0] m);
        ld_vld[t] = 1; ld_addr[t] = a; ld_mask[t] = m;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; cm_ready = 0;
        st_addr = '0; st_data = '0; st_mask = '0; ld_addr = '0; ld_mask = '0;
        idle();
        for (int t = 0; t < TH; t++) fcnt_m[t] = 0;
        repeat (3) @(negedge clk);
        #2;
        chk("R9", "reset commit valid", cm_valid, 0);
        chk("R9", "reset full", st_full, 0);
        rst_n = 1;
        @(negedge clk);
        step();

        // Fill thread 0 while the cache refuses everything
        cm_ready = 0;
        push(0, 32'h100, 32'h1111_1111, 4'hF); step(); idle();
        push(0, 32'h104, 32'h2222_2222, 4'hF); step(); idle();
        push(0, 32'h100, 32'h3333_3333, 4'h3); step(); idle();
        push(0, 32'h108, 32'h4444_4444, 4'hF); step(); idle();
        push(0, 32'h10C, 32'h5555_5555, 4'hF); step(); idle();   // R2 dropped when full
        #2 chk("R2", "still full after drop", st_full[0], 1);
        @(negedge clk);

        load(0, 32'h100, 4'h3); load(1, 32'h100, 4'h3); step("R7"); idle();
        load(0, 32'h100, 4'h3); step("R5"); idle();
        load(0, 32'h100, 4'hF); step("R6"); idle();
        load(0, 32'h104, 4'h4); step("R5"); idle();
        load(0, 32'h200, 4'hF); step("R10"); idle();

        push(1, 32'h300, 32'hAAAA_0001, 4'hF); step(); idle();
        push(1, 32'h304, 32'hAAAA_0002, 4'hF); step(); idle();
        push(1, 32'h308, 32'hAAAA_0003, 4'hF); step(); idle();
        cm_ready = 1;
        repeat (9) step();

        // Fence: two older stores, then one younger store
        cm_ready = 0;
        push(0, 32'h400, 32'hB000_0001, 4'hF); step(); idle();
        push(0, 32'h404, 32'hB000_0002, 4'hF); step(); idle();
        fence[0] = 1; step(); idle();
        push(0, 32'h408, 32'hB000_0003, 4'hF); load(1, 32'h408, 4'hF); step("R8"); idle();
        load(0, 32'h408, 4'hF); step("R8"); idle();
        cm_ready = 1;
        for (int k = 0; k < 5; k++) begin
            load(0, 32'h408, 4'hF);
            step("R8");
            idle();
        end

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            cm_ready = ($urandom % 10) < 6;
            for (int t = 0; t < TH; t++) begin
                st_vld[t]  = $urandom % 2;
                st_addr[t] = 32'h100 + 32'(4 * ($urandom % 4));
                st_data[t] = $urandom;
                st_mask[t] = 4'(($urandom % 15) + 1);
                fence[t]   = ($urandom % 40) == 0;
                ld_vld[t]  = $urandom % 2;
                ld_addr[t] = 32'h100 + 32'(4 * ($urandom % 4));
                ld_mask[t] = 4'(($urandom % 15) + 1);
            end
            step();
        end
        idle();
        cm_ready = 1;
        repeat (12) step();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule